// File: doc/BRIEF.md
# Start-Bit Framed Control Byte Receiver

This block is the device side of a three-wire serial link: an active-low select, a serial clock and a data line from the host, with a data line back to the host. Framing does not begin at the select edge. Once select is low, the receiver skips every 0 on the data line. The first 1 it samples is taken as the start bit of an 8-bit control byte. The seven bits after it are latched onto a parallel output. The receiver then shows a busy indication for one serial-clock period. After that it shifts out a 12-bit result word, which is taken from a parallel input, and then holds its output at 0.

A late start bit therefore delays the busy pulse and the result by the same number of clocks. This makes the block useful as a behavioural model to check a host controller against. The select, serial clock and data inputs are synchronised into the block's own clock domain and edge-detected. Data is sampled on serial-clock rising edges, and the output changes on falling edges.

The state machine has seven states:

- IDLE: select is high.
- HUNT: waiting for the start bit.
- CTRL: receiving the seven control bits.
- ARM: waiting for the falling edge that begins busy.
- BUSY: busy is high for one period.
- SHIFT: the result bits are being sent.
- TAIL: the output stays at 0 until select rises.

The transitions are:

- IDLE→HUNT when select is seen low.
- HUNT→CTRL on a rising edge that samples 1.
- CTRL→ARM on the rising edge that samples the eighth byte bit.
- ARM→BUSY on the next falling edge.
- BUSY→SHIFT on the falling edge after that, which also loads the result.
- SHIFT→TAIL on the falling edge after the last result bit.
- any state→IDLE whenever select is high.

Top module: `sbrx_top`

## Requirements
- R1: After reset, busy, dout and ctrl are all 0.
- R2: With select low, 0 bits sampled on rising serial-clock edges before the first 1 are ignored; the first sampled 1 is the start bit and is not part of ctrl.
- R3: busy rises on the falling serial-clock edge after the rising edge that samples the eighth byte bit (start bit counted as bit one) and stays high for exactly one serial-clock period, falling on the next falling edge.
- R4: A start bit first sampled on clock k puts the busy pulse after clock k+7; a start on clock 4 gives busy high between clocks 11 and 12.
- R5: ctrl[6:0] takes the seven bits following the start bit, the first-received in bit 6, at the rising edge sampling the eighth byte bit, and holds its value at all other times, including across aborted frames.
- R6: dout is 0 from select falling until busy falls, including while the control byte is received and while busy is high.
- R7: On the falling edge that ends busy, the result input is captured and its bit 11 placed on dout; each following falling edge presents the next lower bit, so bit 0 is shown after the twelfth such edge.
- R8: With the start bit on clock 1, a 24-clock frame carries the control byte on clocks 1-8, busy during clock 9, result bits during clocks 10-21, and dout is 0 during clocks 22-24.
- R9: Select going high at any point aborts the frame: busy and dout go to 0, and the next select-low period hunts for a new start bit and frames normally.
- R10: busy is 0 while select is high and when select falls; no busy pulse occurs while only 0 bits are clocked in.
- R11: After the control byte, data-line values have no effect for the rest of the frame: 1 bits produce neither a second busy pulse nor any change to dout or ctrl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host, sampled on sclk rise |
| result | input | 12 | Result word to send, captured when busy ends |
| busy | output | 1 | One-period conversion indication |
| dout | output | 1 | Serial data to the host, changes on sclk fall |
| ctrl | output | 7 | Latched control bits following the start bit |

## Verification
The embedded assertions watch these properties on every clock:

- busy comes up only from the armed state on a falling edge.
- busy ends only on a falling edge or a select release.
- busy is low the cycle after select is seen high.
- dout is never 1 while busy.
- zeros sampled while hunting keep the receiver hunting.
- ctrl moves only on a byte-completion strobe.
- the result counter stays in range.

The directed scenarios are needed to show the clock-accurate placement of busy for start bits at different offsets and the order of the result bits. They also show recovery after aborts in the middle of the control byte and in the middle of the result, and that data-line activity after the byte is ignored.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

    localparam int CTRL_BITS   = 8;
    localparam int RES_BITS    = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_CTRL,
        ST_ARM,
        ST_BUSY,
        ST_SHIFT,
        ST_TAIL
    } sbrx_state_e;

endpackage

// File: rtl/sbrx_sync.sv
module sbrx_sync #(
    parameter int STAGES = sbrx_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_hi,
    output logic din_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    // bit order {cs_n, sclk, din}; select idles high
    localparam logic [2:0] RST_VAL = 3'b100;

    logic [2:0] pipe [STAGES];
    logic       sclk_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= {cs_n, sclk, din};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= pipe[STAGES-1][1];
    end

    assign cs_hi     = pipe[STAGES-1][2];
    assign din_s     = pipe[STAGES-1][0];
    assign sclk_rise =  pipe[STAGES-1][1] & ~sclk_prev;
    assign sclk_fall = ~pipe[STAGES-1][1] &  sclk_prev;

endmodule

// File: rtl/sbrx_fsm.sv
module sbrx_fsm
    import sbrx_pkg::*;
#(
    parameter int CTRL_W = CTRL_BITS,
    parameter int RES_W  = RES_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_hi,
    input  logic din_s,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic busy,
    output logic ctrl_shift,
    output logic ctrl_done,
    output logic res_load,
    output logic res_shift,
    output logic shifting
);
    localparam int CNT_MAX = (CTRL_W > RES_W) ? CTRL_W : RES_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 2);
    localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_W - 1);

    sbrx_state_e state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        if (cs_hi) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_HUNT;
                ST_HUNT:  if (sclk_rise && din_s) state_d = ST_CTRL;
                ST_CTRL:  if (sclk_rise && cnt == CTRL_LAST) state_d = ST_ARM;
                ST_ARM:   if (sclk_fall) state_d = ST_BUSY;
                ST_BUSY:  if (sclk_fall) state_d = ST_SHIFT;
                ST_SHIFT: if (sclk_fall && cnt == RES_LAST) state_d = ST_TAIL;
                ST_TAIL:  state_d = ST_TAIL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // bit counter
    always_comb begin
        cnt_d = cnt;
        if (state_d != state)
            cnt_d = '0;
        else if ((state == ST_CTRL && sclk_rise) || (state == ST_SHIFT && sclk_fall))
            cnt_d = cnt + 1'b1;
    end

    // outputs and strobes
    always_comb begin
        busy       = 1'b0;
        ctrl_shift = 1'b0;
        ctrl_done  = 1'b0;
        res_load   = 1'b0;
        res_shift  = 1'b0;
        shifting   = 1'b0;
        unique case (state)
            ST_CTRL: begin
                ctrl_shift = sclk_rise & ~cs_hi;
                ctrl_done  = sclk_rise & ~cs_hi & (cnt == CTRL_LAST);
            end
            ST_BUSY: begin
                busy     = 1'b1;
                res_load = sclk_fall & ~cs_hi;
            end
            ST_SHIFT: begin
                shifting  = 1'b1;
                res_shift = sclk_fall & ~cs_hi;
            end
            ST_IDLE, ST_HUNT, ST_ARM, ST_TAIL: ;
            default: ;
        endcase
    end

    // R10: select seen high clears busy by the next cycle
    a_r10_busy_low_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !busy);

    // R3: busy starts only from a falling edge while armed
    a_r3_busy_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sclk_fall) && $past(state) == ST_ARM);

    // R3 / R9: busy ends only on a falling edge or select release
    a_r3_busy_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(sclk_fall) || $past(cs_hi));

    // R2: a zero sampled while hunting keeps the receiver hunting
    a_r2_zero_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && sclk_rise && !din_s && !cs_hi) |=> state == ST_HUNT);

    // R7: result bit counter stays within the word
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> cnt <= RES_LAST);

endmodule

// File: rtl/sbrx_datapath.sv
module sbrx_datapath
    import sbrx_pkg::*;
#(
    parameter int CTRL_W = CTRL_BITS,
    parameter int RES_W  = RES_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_s,
    input  logic              ctrl_shift,
    input  logic              ctrl_done,
    input  logic              res_load,
    input  logic              res_shift,
    input  logic              shifting,
    input  logic [RES_W-1:0]  result,
    output logic [CTRL_W-2:0] ctrl,
    output logic              dout
);
    localparam int ACC_W = CTRL_W - 2;

    logic [ACC_W-1:0]  acc;
    logic [CTRL_W-2:0] ctrl_q;
    logic [RES_W-1:0]  res_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            ctrl_q <= '0;
        end else begin
            if (ctrl_shift) acc <= {acc[ACC_W-2:0], din_s};
            if (ctrl_done)  ctrl_q <= {acc, din_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         res_sh <= '0;
        else if (res_load)  res_sh <= result;
        else if (res_shift) res_sh <= {res_sh[RES_W-2:0], 1'b0};
    end

    assign ctrl = ctrl_q;
    assign dout = shifting & res_sh[RES_W-1];

    // R5: the latched control bits move only on byte completion
    a_r5_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_done |=> $stable(ctrl_q));

endmodule

// File: rtl/sbrx_top.sv
module sbrx_top
    import sbrx_pkg::*;
#(
    parameter int CTRL_W = CTRL_BITS,
    parameter int RES_W  = RES_BITS,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [RES_W-1:0]  result,
    output logic              busy,
    output logic              dout,
    output logic [CTRL_W-2:0] ctrl
);
    logic cs_hi, din_s, sclk_rise, sclk_fall;
    logic ctrl_shift, ctrl_done, res_load, res_shift, shifting;

    sbrx_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .cs_hi     (cs_hi),
        .din_s     (din_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    sbrx_fsm #(.CTRL_W(CTRL_W), .RES_W(RES_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_hi      (cs_hi),
        .din_s      (din_s),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .busy       (busy),
        .ctrl_shift (ctrl_shift),
        .ctrl_done  (ctrl_done),
        .res_load   (res_load),
        .res_shift  (res_shift),
        .shifting   (shifting)
    );

    sbrx_datapath #(.CTRL_W(CTRL_W), .RES_W(RES_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .din_s      (din_s),
        .ctrl_shift (ctrl_shift),
        .ctrl_done  (ctrl_done),
        .res_load   (res_load),
        .res_shift  (res_shift),
        .shifting   (shifting),
        .result     (result),
        .ctrl       (ctrl),
        .dout       (dout)
    );

    // R6: no result data while busy is shown
    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout);

endmodule

// File: tb/sbrx_top_bench.sv
module sbrx_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // block clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] result = '0;
    logic        busy, dout;
    logic [6:0]  ctrl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [6:0] exp_ctrl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbrx_top u_sbrx_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .result(result), .busy(busy), .dout(dout), .ctrl(ctrl)
    );

    task automatic chk(input string tag, input int c, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s clock %0d: actual %h expected %h", tag, c, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial clock; returns at a point after the falling edge has settled
    task automatic clock_bit(input logic v);
        @(negedge clk); din = v;
        wait_clks(HALF);
        sclk = 1'b1;
        wait_clks(HALF);
        sclk = 1'b0;
        wait_clks(HALF - 2);
    endtask

    // lead zeros, start, 7 control bits, then din_after; select released after 'total' clocks
    task automatic run_frame(input string tag, input int lead, input logic [6:0] cbits,
                             input logic [11:0] res, input int total, input logic din_after);
        int s;
        logic [6:0] prior;
        s = lead + 1;
        prior = exp_ctrl;
        @(negedge clk); result = res; cs_n = 1'b0;
        wait_clks(HALF);
        chk({tag, "/R10 busy at select fall"}, 0, busy, 0);
        for (int c = 1; c <= total; c++) begin
            logic v, eb, ed;
            if (c <= lead)          v = 1'b0;
            else if (c == s)        v = 1'b1;
            else if (c <= s + 7)    v = cbits[6 - (c - s - 1)];
            else                    v = din_after;
            clock_bit(v);
            eb = (c == s + 7);
            ed = (c >= s + 8 && c <= s + 19) ? res[11 - (c - s - 8)] : 1'b0;
            chk({tag, "/R3 R4 busy"}, c, busy, eb);
            chk({tag, "/R6 R7 R8 dout"}, c, dout, ed);
            chk({tag, "/R5 ctrl"}, c, ctrl, (c >= s + 7) ? cbits : prior);
        end
        if (total >= s + 7) exp_ctrl = cbits;
        @(negedge clk); cs_n = 1'b1; din = 1'b0;
        wait_clks(HALF);
        chk({tag, "/R9 busy after release"}, total, busy, 0);
        chk({tag, "/R9 dout after release"}, total, dout, 0);
        chk({tag, "/R5 ctrl after release"}, total, ctrl, exp_ctrl);
    endtask

    task automatic t_reset();
        chk("R1 busy", 0, busy, 0);
        chk("R1 dout", 0, dout, 0);
        chk("R1 ctrl", 0, ctrl, 0);
    endtask

    task automatic t_aligned();   // R8 full 24-clock frame
        run_frame("R8 aligned", 0, 7'h4B, 12'hA5C, 24, 1'b0);
    endtask

    task automatic t_late_start(); // R4 start on clock 4, busy after clock 11; R2
        run_frame("R4 late", 3, 7'h33, 12'h3C9, 27, 1'b0);
        run_frame("R2 leadzeros", 9, 7'h61, 12'h801, 33, 1'b0);
    endtask

    task automatic t_patterns();   // R2 zeros inside byte are data; R7 bit order
        run_frame("R2 zeroctrl", 1, 7'h00, 12'hFFF, 25, 1'b0);
        run_frame("R7 alt", 0, 7'h7F, 12'h001, 24, 1'b0);
    endtask

    task automatic t_tail_ignored(); // R11
        run_frame("R11 tail", 2, 7'h2A, 12'h5A5, 30, 1'b1);
    endtask

    task automatic t_no_start();     // R10 zeros only, no busy
        @(negedge clk); cs_n = 1'b0;
        wait_clks(HALF);
        for (int c = 1; c <= 14; c++) begin
            clock_bit(1'b0);
            chk("R10 zeros no busy", c, busy, 0);
            chk("R10 zeros dout", c, dout, 0);
        end
        @(negedge clk); cs_n = 1'b1;
        wait_clks(HALF);
        chk("R5 ctrl unchanged", 0, ctrl, exp_ctrl);
    endtask

    task automatic t_aborts();       // R9 abort in byte, in busy, in result, then recover
        run_frame("R9 abort ctrl", 1, 7'h15, 12'h123, 5, 1'b0);
        run_frame("R9 recover1", 0, 7'h6E, 12'hC3A, 24, 1'b0);
        run_frame("R9 abort busy", 0, 7'h19, 12'hFFF, 8, 1'b0);
        run_frame("R9 abort shift", 0, 7'h44, 12'hFFF, 13, 1'b0);
        run_frame("R9 recover2", 4, 7'h0D, 12'h7E1, 28, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clks(4);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        wait_clks(4);
        t_reset();
        t_aligned();
        t_late_start();
        t_patterns();
        t_tail_ignored();
        t_no_start();
        t_aborts();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule